// File: doc/BRIEF.md
# Passive Serial Configuration Master

This block loads an SRAM-based programmable device over its passive serial port. After a single-cycle `start` in idle, it latches a byte total and pulls the active-low configuration request low for a fixed reset pulse. It then confirms that the device is holding its active-low status line low. After releasing the request, it waits for the device to let the status line go high. If the device does not respond in time, the load is aborted.

Once the device is ready, bytes arrive over a valid/ready input. Each byte goes out on a serial clock and data pair, least significant bit first. A new byte is taken only when the bit shifter has drained. While no byte is offered, the serial clock rests low. After the last byte, the block samples the configuration-done input. If done is high, it sends a short burst of extra clock pulses and reports success. Any failure raises a one-cycle abort pulse and leaves a cause code that stays visible until the next start.

Both device inputs pass through two-flop synchronisers. All delays are parameters. The microsecond delays are derived from the system clock frequency, and the serial half-period is counted in system-clock cycles.

Top module: `ps_cfg_master`

## Requirements
- R1: After reset, and while idle, `cfg_req_n`=1, `dclk`=0, `busy`=0, `cfg_ok`=0, `err_code`=0, `abort`=0 and `in_ready`=0. While `cfg_req_n` is low, `dclk` stays low.
- R2: A `start` in idle drives `cfg_req_n` low for exactly REQ_CYC = ceil(CLK_FREQ_HZ*REQ_US/1e6) cycles, with REQ_US defaulting to 3.
- R3: If the synchronised `status_n` is not low at the end of the request pulse, the load aborts with `err_code`=1, and no `dclk` pulse is issued.
- R4: After the request is released, if `status_n` is not seen high within TMO_CYC = ceil(CLK_FREQ_HZ*TIMEOUT_US/1e6) cycles, the load aborts with `err_code`=2, and no `dclk` pulse is issued.
- R5: Each byte is shifted out bit 0 first, one bit per rising edge of `dclk`. `ddata` changes only while `dclk` is low. Every high phase of `dclk` lasts HALF_CYC cycles.
- R6: Exactly `byte_count` bytes are accepted (`in_valid`&&`in_ready`), and only while the shifter is empty. While no byte is offered, `dclk` stays low and `in_ready` stays high.
- R7: If `conf_done` is low after the last byte, the load aborts with `err_code`=3, and no trailing pulse is sent (rising edges = 8*byte_count).
- R8: If `conf_done` is high after the last byte, exactly TRAIL_N (12) further `dclk` pulses follow, each high then low. After them, `cfg_ok`=1 and `busy`=0.
- R9: `abort` is high for exactly one cycle per failure. `err_code` holds until the next `start`, and that `start` clears both `err_code` and `cfg_ok`.
- R10: A `start` while `busy` is ignored: neither the latched byte total nor the sequence changes.
- R11: A `byte_count` of 0 goes directly from the status handshake to the done check. On success, only the 12 trailing pulses appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (honoured only when idle) |
| byte_count | input | CNT_W | Number of bytes to send, latched at start |
| in_data | input | BYTE_W | Byte offered for shifting |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Shifter empty and bytes still owed |
| cfg_req_n | output | 1 | Active-low configuration request to the device |
| dclk | output | 1 | Serial configuration clock |
| ddata | output | 1 | Serial configuration data |
| status_n | input | 1 | Active-low device status (asynchronous) |
| conf_done | input | 1 | Device configuration-done flag (asynchronous) |
| busy | output | 1 | Sequence in progress |
| cfg_ok | output | 1 | Last load succeeded (held) |
| err_code | output | 2 | 0 none, 1 status not asserted, 2 release timeout, 3 done missing |
| abort | output | 1 | One-cycle failure pulse |

## Verification
The assertions assume that `start`, `in_valid` and `in_data` are free of X after reset. They also assume that `in_data` stays steady while `in_valid` waits for `in_ready`. The device lines are taken to hold each level for many clock cycles, so the synchronisers see clean transitions. The bench drives every input on the falling clock edge and holds `in_valid` until it has seen the handshake. Its device model keeps the status line steady for at least twenty cycles after each change of the request pin, and holds `conf_done` constant for the whole of each load.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_NO_STATUS = 2'd1,
    ERR_TIMEOUT   = 2'd2,
    ERR_NO_DONE   = 2'd3
  } ps_err_e;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_WREL, S_LOAD, S_DCHK, S_TRAIL
  } ps_state_e;

  // Round a microsecond delay up to whole system-clock cycles.
  function automatic longint unsigned us_to_cycles(longint unsigned f_hz,
                                                   longint unsigned us);
    return (f_hz * us + 64'd999_999) / 64'd1_000_000;
  endfunction

  // Bits needed to count 0 .. n-1 (at least one).
  function automatic int unsigned cnt_bits(longint unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/ps_sync2.sv
module ps_sync2 #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta, stab;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      stab <= RST_VAL;
    end else begin
      meta <= d;
      stab <= meta;
    end
  end

  assign q = stab;
endmodule

// File: rtl/ps_bit_shifter.sv
module ps_bit_shifter
  import ps_cfg_pkg::*;
#(
  parameter int unsigned HALF_CYC = 2,
  parameter int unsigned BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              empty,
  output logic              sclk,
  output logic              sdat,
  output logic              byte_end
);
  localparam int unsigned HC_W  = cnt_bits(HALF_CYC);
  localparam int unsigned IDX_W = cnt_bits(BYTE_W);

  logic              active, phase_hi, sdat_r;
  logic [HC_W-1:0]   hcnt;
  logic [IDX_W-1:0]  idx, idx_nx;
  logic [BYTE_W-1:0] sreg;
  logic              half_end, last_bit;

  assign idx_nx   = idx + IDX_W'(1);
  assign half_end = active && (hcnt == HC_W'(HALF_CYC - 1));
  assign last_bit = (idx == IDX_W'(BYTE_W - 1));
  assign byte_end = half_end && phase_hi && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      phase_hi <= 1'b0;
      hcnt     <= '0;
      idx      <= '0;
      sreg     <= '0;
      sdat_r   <= 1'b0;
    end else if (load && !active) begin
      active   <= 1'b1;
      phase_hi <= 1'b0;
      hcnt     <= '0;
      idx      <= '0;
      sreg     <= byte_in;
      sdat_r   <= byte_in[0];
    end else if (active) begin
      if (half_end) begin
        hcnt <= '0;
        if (!phase_hi) begin
          phase_hi <= 1'b1;
        end else begin
          phase_hi <= 1'b0;
          if (last_bit) begin
            active <= 1'b0;
          end else begin
            idx    <= idx_nx;
            sdat_r <= sreg[idx_nx];
          end
        end
      end else begin
        hcnt <= hcnt + HC_W'(1);
      end
    end
  end

  assign empty = !active;
  assign sclk  = active && phase_hi;
  assign sdat  = sdat_r;

  // R6
  load_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !active);

  // R5
  data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdat));
endmodule

// File: rtl/ps_cfg_seq.sv
module ps_cfg_seq
  import ps_cfg_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 50_000_000,
  parameter int unsigned REQ_US      = 3,
  parameter int unsigned TIMEOUT_US  = 100_000,
  parameter int unsigned HALF_CYC    = 2,
  parameter int unsigned TRAIL_N     = 12,
  parameter int unsigned CNT_W       = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             status_n_s,
  input  logic             conf_done_s,
  input  logic             shifter_empty,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             cfg_req_n,
  output logic             trail_clk,
  output logic             busy,
  output logic             cfg_ok,
  output logic [1:0]       err_code,
  output logic             abort
);
  localparam longint unsigned REQ_CYC = us_to_cycles(CLK_FREQ_HZ, REQ_US);
  localparam longint unsigned TMO_CYC = us_to_cycles(CLK_FREQ_HZ, TIMEOUT_US);
  localparam longint unsigned TMAX    = (REQ_CYC > TMO_CYC) ? REQ_CYC : TMO_CYC;
  localparam int unsigned     T_W     = cnt_bits(TMAX + 1);
  localparam int unsigned     HC_W    = cnt_bits(HALF_CYC);
  localparam int unsigned     P_W     = cnt_bits(TRAIL_N + 1);

  ps_state_e        state;
  ps_err_e          err_r;
  logic [T_W-1:0]   tmr;
  logic [CNT_W-1:0] remaining;
  logic             ok_r, abort_r;
  logic             tr_hi;
  logic [HC_W-1:0]  tr_hcnt;
  logic [P_W-1:0]   tr_cnt;

  // Named internal events
  logic req_end, tmo_hit, take, load_done, tr_half_end, tr_finish;

  assign req_end     = (state == S_REQ)  && (tmr == T_W'(REQ_CYC - 1));
  assign tmo_hit     = (state == S_WREL) && !status_n_s && (tmr == T_W'(TMO_CYC - 1));
  assign in_ready    = (state == S_LOAD) && shifter_empty && (remaining != '0);
  assign take        = in_valid && in_ready;
  assign load_done   = (state == S_LOAD) && shifter_empty && (remaining == '0);
  assign tr_half_end = (state == S_TRAIL) && (tr_hcnt == HC_W'(HALF_CYC - 1));
  assign tr_finish   = tr_half_end && !tr_hi && (tr_cnt == P_W'(TRAIL_N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      err_r     <= ERR_NONE;
      tmr       <= '0;
      remaining <= '0;
      ok_r      <= 1'b0;
      abort_r   <= 1'b0;
      tr_hi     <= 1'b0;
      tr_hcnt   <= '0;
      tr_cnt    <= '0;
    end else begin
      abort_r <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          state     <= S_REQ;
          tmr       <= '0;
          remaining <= byte_count;
          ok_r      <= 1'b0;
          err_r     <= ERR_NONE;
        end
        S_REQ: begin
          if (req_end) begin
            tmr <= '0;
            if (status_n_s) begin
              state   <= S_IDLE;
              err_r   <= ERR_NO_STATUS;
              abort_r <= 1'b1;
            end else begin
              state <= S_WREL;
            end
          end else begin
            tmr <= tmr + T_W'(1);
          end
        end
        S_WREL: begin
          if (status_n_s) begin
            state <= S_LOAD;
          end else if (tmo_hit) begin
            state   <= S_IDLE;
            err_r   <= ERR_TIMEOUT;
            abort_r <= 1'b1;
          end else begin
            tmr <= tmr + T_W'(1);
          end
        end
        S_LOAD: begin
          if (take) remaining <= remaining - CNT_W'(1);
          if (load_done) state <= S_DCHK;
        end
        S_DCHK: begin
          if (conf_done_s) begin
            state   <= S_TRAIL;
            tr_hi   <= 1'b1;
            tr_hcnt <= '0;
            tr_cnt  <= '0;
          end else begin
            state   <= S_IDLE;
            err_r   <= ERR_NO_DONE;
            abort_r <= 1'b1;
          end
        end
        S_TRAIL: begin
          if (tr_half_end) begin
            tr_hcnt <= '0;
            if (tr_hi) begin
              tr_hi <= 1'b0;
            end else if (tr_finish) begin
              state <= S_IDLE;
              ok_r  <= 1'b1;
            end else begin
              tr_cnt <= tr_cnt + P_W'(1);
              tr_hi  <= 1'b1;
            end
          end else begin
            tr_hcnt <= tr_hcnt + HC_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cfg_req_n = (state != S_REQ);
  assign trail_clk = (state == S_TRAIL) && tr_hi;
  assign busy      = (state != S_IDLE);
  assign cfg_ok    = ok_r;
  assign err_code  = err_r;
  assign abort     = abort_r;

  // R9
  abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);

  // R8
  ok_without_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |-> (err_code == 2'd0));

  // R6
  ready_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && shifter_empty));

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && state != S_REQ) |=> (state != S_REQ));
endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
  import ps_cfg_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 50_000_000,
  parameter int unsigned REQ_US      = 3,
  parameter int unsigned TIMEOUT_US  = 100_000,
  parameter int unsigned HALF_CYC    = 2,
  parameter int unsigned TRAIL_N     = 12,
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              cfg_req_n,
  output logic              dclk,
  output logic              ddata,
  input  logic              status_n,
  input  logic              conf_done,
  output logic              busy,
  output logic              cfg_ok,
  output logic [1:0]        err_code,
  output logic              abort
);
  logic [1:0] pins_s;
  logic       status_n_s, conf_done_s;
  logic       sh_empty, sh_clk, sh_dat, sh_byte_end, tr_clk, load;

  ps_sync2 #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({conf_done, status_n}), .q(pins_s)
  );
  assign status_n_s  = pins_s[0];
  assign conf_done_s = pins_s[1];

  assign load = in_valid && in_ready;

  ps_bit_shifter #(.HALF_CYC(HALF_CYC), .BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .byte_in(in_data),
    .empty(sh_empty), .sclk(sh_clk), .sdat(sh_dat), .byte_end(sh_byte_end)
  );

  ps_cfg_seq #(
    .CLK_FREQ_HZ(CLK_FREQ_HZ), .REQ_US(REQ_US), .TIMEOUT_US(TIMEOUT_US),
    .HALF_CYC(HALF_CYC), .TRAIL_N(TRAIL_N), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .status_n_s(status_n_s), .conf_done_s(conf_done_s),
    .shifter_empty(sh_empty), .in_valid(in_valid), .in_ready(in_ready),
    .cfg_req_n(cfg_req_n), .trail_clk(tr_clk), .busy(busy),
    .cfg_ok(cfg_ok), .err_code(err_code), .abort(abort)
  );

  assign dclk  = sh_clk | tr_clk;
  assign ddata = sh_dat;

  // R1
  quiet_during_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_req_n |-> !dclk);

  // R8
  clk_sources_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sh_clk && tr_clk));

  // R5
  byte_end_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_byte_end |-> dclk);
endmodule

// File: tb/tb_ps_cfg_master.sv
module tb_ps_cfg_master;
  localparam int HALF    = 2;
  localparam int REQ_CYC = 150;   // 50 MHz * 3 us
  localparam int TMO_CYC = 2000;  // 50 MHz * 40 us
  localparam int TRAIL   = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
  logic [23:0] byte_count = '0;
  logic [7:0]  in_data = '0;
  logic in_ready, cfg_req_n, dclk, ddata, status_n, busy, cfg_ok, abort;
  logic conf_done = 1'b0;
  logic [1:0] err_code;

  int checks = 0, failures = 0, cycles = 0;
  int dev_mode = 0;
  int rel_cnt = 20;
  int rises = 0;
  int hi_run = 0, bad_hi = 0;
  logic cap_bit [0:4095];

  always #10 clk = ~clk;

  ps_cfg_master #(.CLK_FREQ_HZ(50_000_000), .REQ_US(3), .TIMEOUT_US(40),
                  .HALF_CYC(HALF), .TRAIL_N(TRAIL)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .cfg_req_n(cfg_req_n), .dclk(dclk), .ddata(ddata), .status_n(status_n),
    .conf_done(conf_done), .busy(busy), .cfg_ok(cfg_ok),
    .err_code(err_code), .abort(abort)
  );

  // Device model: 0 normal, 1 never pulls status low, 2 never releases it
  always @(posedge clk) begin
    if (!cfg_req_n) rel_cnt <= 0;
    else if (rel_cnt < 20) rel_cnt <= rel_cnt + 1;
  end
  assign status_n = (dev_mode == 1) ? 1'b1 :
                    (!cfg_req_n)    ? 1'b0 :
                    (dev_mode == 2) ? 1'b0 : (rel_cnt >= 20);

  // Serial capture at each rising edge of dclk
  always @(posedge dclk) begin
    if (rises < 4096) cap_bit[rises] = ddata;
    rises = rises + 1;
  end

  // High-phase width monitor
  always @(negedge clk) begin
    if (dclk) hi_run = hi_run + 1;
    else begin
      if (hi_run != 0 && hi_run != HALF) bad_hi = bad_hi + 1;
      hi_run = 0;
    end
  end

  always @(posedge clk) cycles <= cycles + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int i, int v);
    return 8'(32'hA5 ^ (i * 37 + v * 11));
  endfunction

  // {n[14:7], mode[6:5], done[4], gap[3], poke[2], err[1:0]}
  localparam logic [14:0] VEC [8] = '{
    {8'd4, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0},
    {8'd1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd0},
    {8'd0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0},
    {8'd3, 2'd1, 1'b1, 1'b0, 1'b0, 2'd1},
    {8'd2, 2'd2, 1'b1, 1'b0, 1'b0, 2'd2},
    {8'd2, 2'd0, 1'b0, 1'b0, 1'b0, 2'd3},
    {8'd5, 2'd0, 1'b1, 1'b1, 1'b0, 2'd0},
    {8'd2, 2'd0, 1'b1, 1'b0, 1'b1, 2'd0}
  };

  task automatic run_vector(input int v);
    int n, mode, gap_mode, poke, exp_err, base, i, gap, req_lo, wcnt, ab, loopc;
    int exp_rises, exp_take;
    bit pend, first, stall_ok;
    n        = int'(VEC[v][14:7]);
    mode     = int'(VEC[v][6:5]);
    gap_mode = int'(VEC[v][3]);
    poke     = int'(VEC[v][2]);
    exp_err  = int'(VEC[v][1:0]);
    dev_mode = mode;
    conf_done = VEC[v][4];
    base = rises; i = 0; gap = 0; req_lo = 0; wcnt = 0; ab = 0; loopc = 0;
    pend = 0; first = 1; stall_ok = 1;
    @(negedge clk);
    byte_count = 24'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    forever begin
      if (first) begin
        // R9: a new start clears the held cause and success flag
        chk(err_code == 2'd0 && !cfg_ok && busy, "R9 start clears status", int'(err_code), 0);
        first = 0;
      end
      if (abort) ab = ab + 1;
      if (!cfg_req_n) req_lo = req_lo + 1;
      if (busy && cfg_req_n) wcnt = wcnt + 1;
      if (pend) begin i = i + 1; in_valid = 1'b0; gap = 0; pend = 0; end
      if (!busy) break;
      loopc = loopc + 1;
      if (poke != 0 && loopc == 200) begin
        byte_count = 24'd9;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (i < n && !in_valid) begin
        if (gap_mode != 0 && i > 0 && gap < 40) begin
          gap = gap + 1;
          if (gap == 40 && (dclk || !in_ready)) stall_ok = 0;
        end else begin
          in_valid = 1'b1;
          in_data  = pat(i, v);
        end
      end
      if (in_valid && in_ready) pend = 1;
      @(negedge clk);
    end
    start = 1'b0;
    in_valid = 1'b0;

    exp_take  = (exp_err == 0 || exp_err == 3) ? n : 0;
    exp_rises = (exp_err == 0) ? 8 * n + TRAIL : (exp_err == 3) ? 8 * n : 0;

    chk(int'(err_code) == exp_err, "R3/R4/R7 error cause", int'(err_code), exp_err);
    // R8
    chk(cfg_ok == (exp_err == 0), "R8 success flag", int'(cfg_ok), int'(exp_err == 0));
    // R2
    chk(req_lo == REQ_CYC, "R2 request pulse width", req_lo, REQ_CYC);
    // R9
    chk(ab == ((exp_err != 0) ? 1 : 0), "R9 abort pulse count", ab, (exp_err != 0) ? 1 : 0);
    // R6 / R10
    chk(i == exp_take, "R6 R10 bytes accepted", i, exp_take);
    // R7 / R8 / R11 / R3 / R4
    chk(rises - base == exp_rises, "R8 R7 R11 dclk rising edges", rises - base, exp_rises);
    if (exp_err == 2)
      chk(wcnt >= TMO_CYC - 2 && wcnt <= TMO_CYC + 2, "R4 release timeout", wcnt, TMO_CYC);
    if (gap_mode != 0 && n > 1)
      chk(stall_ok, "R6 clock low while starved", int'(stall_ok), 1);
    for (int b = 0; b < exp_take; b++) begin
      logic [7:0] got;
      for (int k = 0; k < 8; k++) got[k] = cap_bit[base + 8 * b + k];
      // R5
      chk(got == pat(b, v), "R5 LSB-first byte", int'(got), int'(pat(b, v)));
    end
    // R5
    chk(bad_hi == 0, "R5 high phase width", bad_hi, 0);
    if (exp_err != 0) begin
      repeat (20) @(negedge clk);
      // R9
      chk(int'(err_code) == exp_err && !busy, "R9 cause held", int'(err_code), exp_err);
    end
    repeat (5) @(negedge clk);
  endtask

  initial begin
    while (cycles < 150000) @(posedge clk);
    failures = failures + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(cfg_req_n && !dclk && !busy && !cfg_ok && !abort && !in_ready && err_code == 2'd0,
        "R1 reset state", int'({cfg_req_n, dclk, busy, cfg_ok, abort, in_ready}), 32);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cfg_req_n && !busy && !dclk, "R1 idle after release", int'({cfg_req_n, busy, dclk}), 4);

    for (int v = 0; v < 8; v++) run_vector(v);

    // R1: reset in the middle of a load returns to the idle state
    dev_mode = 0; conf_done = 1'b1;
    @(negedge clk);
    byte_count = 24'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (50) @(negedge clk);
    chk(busy && !cfg_req_n, "R1 mid-pulse busy", int'({busy, cfg_req_n}), 2);
    rst_n = 1'b0;
    @(negedge clk);
    chk(cfg_req_n && !dclk && !busy && !cfg_ok && !abort && !in_ready && err_code == 2'd0,
        "R1 async reset mid-load", int'({cfg_req_n, dclk, busy, cfg_ok, abort, in_ready}), 32);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule